// File: doc/BRIEF.md
# Page Access Permission Checker

This block rules on whether a requested memory access may proceed while a page-table walker visits the levels of a translation hierarchy. When a walk begins, the walker pulses `walk_go` together with the access request: which kinds of access to validate (read, write, execute), whether supervisor-mode user-page protection for data is to be overridden or enforced, and a three-bit privilege check mode. Along with these it presents the mode controls: execute-protection enable, the two supervisor protections (one for instruction fetch, one for data), the alignment-check flag and the stack segment's privilege level. From these the block derives the effective user and supervisor checks and a restriction flag that forbids a supervisor from touching a user page.

For each entry visited, the walker pulses `lvl_vld` with the entry's present, writable, user and no-execute bits, a last-level marker and three error inputs for that step. One cycle later the block pulses `res_vld` and gives a result code. Once a fault has been reported, every later step of the same walk gets that same fault until the next `walk_go`. Address arithmetic and memory accesses are not part of this block.

Top module: `pg_perm_chk`

## Requirements
- R1: The mode `chk_mode` selects the checks: 0 selects none, 1 selects user only, 2 selects supervisor only, 3 selects both, and 4 selects user when `ss_dpl` equals 3 and supervisor otherwise. Values 5 to 7 act as 0.
- R2: When `nx_en` is 0 at `walk_go`, execute validation is off for the whole walk. A set no-execute bit then causes no fault.
- R3: Each `lvl_vld` produces exactly one `res_vld` pulse, one cycle later. `res_vld` is 0 at all other times.
- R4: Result codes are 0 pass, 1 invalid-flags, 2 unmapped, 3 not-present and 4 privilege. When several faults apply, the priority is unmapped, then invalid-flags (`rsv_err` or `noncanon`), then not-present, then privilege.
- R5: An entry whose present bit is 0 gives not-present, even when its permission bits would also fail.
- R6: A present entry gives privilege in any of these cases: write is validated and writable is 0; execute is validated and no-execute is 1; the user check is on and the user bit is 0.
- R7: The restriction flag is set at `walk_go` when the supervisor check is on and either of two cases holds. In the first, execute is validated (after R2) and `smep` is 1. In the second, read or write is validated, `smap` is 1, `ovr_smap` is 0, and either `enf_smap` is 1 or `ac_flag` is 0.
- R8: A terminal entry (`lvl_last`=1) with its user bit at 1 gives privilege while the restriction flag is set.
- R9: A passing entry whose user bit is 0 clears the restriction flag for the rest of the walk.
- R10: Once a fault has been reported, every later step gives the same code until the next `walk_go`. A `walk_go` clears the fault and reloads the walk controls.
- R11: After reset, `res_vld` is 0 and `res_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| walk_go | input | 1 | start of a walk; latches the request and mode controls |
| val_rd | input | 1 | validate read |
| val_wr | input | 1 | validate write |
| val_ex | input | 1 | validate execute |
| ovr_smap | input | 1 | override data user-page protection |
| enf_smap | input | 1 | enforce data protection regardless of the alignment-check flag |
| chk_mode | input | 3 | privilege check mode |
| nx_en | input | 1 | no-execute enable |
| smep | input | 1 | supervisor fetch protection on |
| smap | input | 1 | supervisor data protection on |
| ac_flag | input | 1 | alignment-check flag |
| ss_dpl | input | 2 | stack segment descriptor privilege level |
| lvl_vld | input | 1 | entry step strobe |
| ent_p | input | 1 | entry present bit |
| ent_w | input | 1 | entry writable bit |
| ent_u | input | 1 | entry user bit |
| ent_nx | input | 1 | entry no-execute bit |
| lvl_last | input | 1 | entry is the terminal one |
| rsv_err | input | 1 | reserved-bit error for this entry |
| noncanon | input | 1 | non-canonical address error |
| unmapped | input | 1 | entry fetch hit unmapped memory |
| res_vld | output | 1 | one-cycle result strobe |
| res_code | output | 3 | result code (R4) |

## Verification
The assertions assume that `walk_go` and `lvl_vld` are never high in the same cycle, and that every walk starts with `walk_go` before its first step. The bench drives each scenario as one `walk_go` followed by separated step strobes, so both assumptions hold. The bench also releases reset before its first walk, which keeps the sticky-fault check from running on values taken before any walk began.

// File: rtl/pg_perm_chk.sv
module pg_perm_chk #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              walk_go,
  input  logic              val_rd,
  input  logic              val_wr,
  input  logic              val_ex,
  input  logic              ovr_smap,
  input  logic              enf_smap,
  input  logic [2:0]        chk_mode,
  input  logic              nx_en,
  input  logic              smep,
  input  logic              smap,
  input  logic              ac_flag,
  input  logic [1:0]        ss_dpl,
  input  logic              lvl_vld,
  input  logic              ent_p,
  input  logic              ent_w,
  input  logic              ent_u,
  input  logic              ent_nx,
  input  logic              lvl_last,
  input  logic              rsv_err,
  input  logic              noncanon,
  input  logic              unmapped,
  output logic              res_vld,
  output logic [CODE_W-1:0] res_code
);
  localparam logic [CODE_W-1:0] C_OK   = CODE_W'(0);
  localparam logic [CODE_W-1:0] C_INV  = CODE_W'(1);
  localparam logic [CODE_W-1:0] C_UNM  = CODE_W'(2);
  localparam logic [CODE_W-1:0] C_NP   = CODE_W'(3);
  localparam logic [CODE_W-1:0] C_PRIV = CODE_W'(4);

  logic w_wr, w_ex, w_usr, w_restr;
  logic faulted;
  logic [CODE_W-1:0] fault_code;

  logic d_usr, d_sup, d_ex, d_restr;
  always_comb begin
    d_usr = 1'b0;
    d_sup = 1'b0;
    case (chk_mode)
      3'd1: d_usr = 1'b1;
      3'd2: d_sup = 1'b1;
      3'd3: begin d_usr = 1'b1; d_sup = 1'b1; end
      3'd4: begin d_usr = (ss_dpl == 2'd3); d_sup = (ss_dpl != 2'd3); end
      default: ;
    endcase
  end
  assign d_ex    = val_ex & nx_en;
  assign d_restr = d_sup & ((d_ex & smep) |
                   ((val_rd | val_wr) & smap & ~ovr_smap & (enf_smap | ~ac_flag)));

  logic [CODE_W-1:0] step_code;
  always_comb begin
    if (unmapped)                         step_code = C_UNM;
    else if (rsv_err | noncanon)          step_code = C_INV;
    else if (!ent_p)                      step_code = C_NP;
    else if ((w_wr & ~ent_w) | (w_ex & ent_nx) | (w_usr & ~ent_u) |
             (lvl_last & w_restr & ent_u)) step_code = C_PRIV;
    else                                  step_code = C_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_wr <= 1'b0; w_ex <= 1'b0; w_usr <= 1'b0; w_restr <= 1'b0;
      faulted <= 1'b0; fault_code <= C_OK;
      res_vld <= 1'b0; res_code <= C_OK;
    end else begin
      res_vld <= lvl_vld;
      if (walk_go) begin
        w_wr <= val_wr; w_ex <= d_ex; w_usr <= d_usr; w_restr <= d_restr;
        faulted <= 1'b0; fault_code <= C_OK;
      end else if (lvl_vld) begin
        if (faulted) begin
          res_code <= fault_code;
        end else begin
          res_code <= step_code;
          if (step_code != C_OK) begin
            faulted <= 1'b1;
            fault_code <= step_code;
          end else if (!ent_u) begin
            w_restr <= 1'b0;
          end
        end
      end
    end
  end
endmodule

module pg_perm_chk_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       lvl_vld,
  input logic       walk_go,
  input logic       ent_p,
  input logic       unmapped,
  input logic       rsv_err,
  input logic       noncanon,
  input logic       res_vld,
  input logic [2:0] res_code
);
  logic stuck;
  logic [2:0] stuck_code;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin stuck <= 1'b0; stuck_code <= 3'd0; end
    else if (walk_go) stuck <= 1'b0;
    else if (res_vld && res_code != 3'd0 && !stuck) begin
      stuck <= 1'b1; stuck_code <= res_code;
    end
  end

  // R3
  res_follows_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_vld |=> res_vld);
  // R3
  res_only_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(lvl_vld));
  // R4
  unmapped_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_vld && unmapped && !stuck) |=> res_code == 3'd2);
  // R5
  not_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_vld && !ent_p && !unmapped && !rsv_err && !noncanon && !stuck) |=> res_code == 3'd3);
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_vld && stuck && !walk_go) |=> res_code == stuck_code);
  // R4
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> res_code <= 3'd4);
endmodule

bind pg_perm_chk pg_perm_chk_sva u_sva (
  .clk(clk), .rst_n(rst_n), .lvl_vld(lvl_vld), .walk_go(walk_go), .ent_p(ent_p),
  .unmapped(unmapped), .rsv_err(rsv_err), .noncanon(noncanon),
  .res_vld(res_vld), .res_code(res_code));

// File: tb/sim_pg_perm_chk.sv
module sim_pg_perm_chk;
  localparam int CLK_PER = 10;
  logic clk = 0, rst_n = 0;
  logic walk_go = 0, val_rd = 0, val_wr = 0, val_ex = 0, ovr_smap = 0, enf_smap = 0;
  logic [2:0] chk_mode = 0;
  logic nx_en = 0, smep = 0, smap = 0, ac_flag = 0;
  logic [1:0] ss_dpl = 0;
  logic lvl_vld = 0, ent_p = 0, ent_w = 0, ent_u = 0, ent_nx = 0, lvl_last = 0;
  logic rsv_err = 0, noncanon = 0, unmapped = 0;
  logic res_vld;
  logic [2:0] res_code;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  pg_perm_chk u0 (.*);

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // mode: {rd,wr,ex,ovr,enf,mode,nx,smep,smap,ac,dpl}
  task automatic start(input logic rd, wr, ex, ovr, enf, input logic [2:0] md,
                       input logic nx, sme, sma, ac, input logic [1:0] dpl);
    @(negedge clk);
    walk_go = 1; val_rd = rd; val_wr = wr; val_ex = ex; ovr_smap = ovr; enf_smap = enf;
    chk_mode = md; nx_en = nx; smep = sme; smap = sma; ac_flag = ac; ss_dpl = dpl;
    @(negedge clk);
    walk_go = 0;
  endtask

  task automatic step(input logic p, w, u, nx, last, rsv, unm, input string req,
                      input logic [2:0] exp);
    @(negedge clk);
    lvl_vld = 1; ent_p = p; ent_w = w; ent_u = u; ent_nx = nx; lvl_last = last;
    rsv_err = rsv; unmapped = unm; noncanon = 0;
    @(negedge clk);
    lvl_vld = 0;
    check({req, " vld"}, {2'b0, res_vld}, 3'd1);
    check(req, res_code, exp);
    @(negedge clk);
    check({req, " R3 single"}, {2'b0, res_vld}, 3'd0);
  endtask

  task automatic t_reset();
    check("R11 vld", {2'b0, res_vld}, 3'd0);
    check("R11 code", res_code, 3'd0);
  endtask

  task automatic t_modes();
    start(0,0,0,0,0,3'd1,0,0,0,0,2'd0);
    step(1,1,0,0,1,0,0,"R1 user mode", 3'd4);
    start(0,0,0,0,0,3'd0,0,0,0,0,2'd0);
    step(1,1,0,0,1,0,0,"R1 none mode", 3'd0);
    start(0,0,0,0,0,3'd4,0,0,0,0,2'd3);
    step(1,1,0,0,1,0,0,"R1 cpl3", 3'd4);
    start(0,0,0,0,0,3'd4,0,0,0,0,2'd0);
    step(1,1,0,0,1,0,0,"R1 cpl0", 3'd0);
    start(0,0,0,0,0,3'd6,0,0,0,0,2'd0);
    step(1,1,0,0,1,0,0,"R1 reserved mode", 3'd0);
  endtask

  task automatic t_nx();
    start(0,0,1,0,0,3'd0,0,0,0,0,2'd0);
    step(1,1,0,1,1,0,0,"R2 nx off", 3'd0);
    start(0,0,1,0,0,3'd0,1,0,0,0,2'd0);
    step(1,1,0,1,1,0,0,"R6 nx on", 3'd4);
    start(0,1,0,0,0,3'd0,0,0,0,0,2'd0);
    step(1,0,0,0,1,0,0,"R6 write ro", 3'd4);
  endtask

  task automatic t_prio();
    start(0,1,0,0,0,3'd1,0,0,0,0,2'd0);
    step(0,0,0,0,0,1,1,"R4 unmapped first", 3'd2);
    start(0,1,0,0,0,3'd1,0,0,0,0,2'd0);
    step(0,0,0,0,0,1,0,"R4 rsv over np", 3'd1);
    start(0,1,0,0,0,3'd1,0,0,0,0,2'd0);
    step(0,0,0,0,0,0,0,"R5 np over priv", 3'd3);
  endtask

  task automatic t_restrict();
    start(1,0,0,0,0,3'd2,0,0,1,0,2'd0);
    step(1,1,1,0,0,0,0,"R7 mid ok", 3'd0);
    step(1,1,1,0,1,0,0,"R8 smap user page", 3'd4);
    start(1,0,0,0,0,3'd2,0,0,1,1,2'd0);
    step(1,1,1,0,1,0,0,"R7 ac set", 3'd0);
    start(1,0,0,0,1,3'd2,0,0,1,1,2'd0);
    step(1,1,1,0,1,0,0,"R7 enforce", 3'd4);
    start(1,0,0,1,0,3'd2,0,0,1,0,2'd0);
    step(1,1,1,0,1,0,0,"R7 override", 3'd0);
    start(0,0,1,0,0,3'd2,1,1,0,0,2'd0);
    step(1,1,1,0,1,0,0,"R7 smep", 3'd4);
    start(1,0,0,0,0,3'd2,0,0,1,0,2'd0);
    step(1,1,0,0,0,0,0,"R9 upper clear", 3'd0);
    step(1,1,1,0,1,0,0,"R9 lifted", 3'd0);
  endtask

  task automatic t_sticky();
    start(0,0,0,0,0,3'd0,0,0,0,0,2'd0);
    step(0,0,0,0,0,0,0,"R10 first", 3'd3);
    step(1,1,1,0,1,0,0,"R10 held", 3'd3);
    start(0,0,0,0,0,3'd0,0,0,0,0,2'd0);
    step(1,1,1,0,1,0,0,"R10 cleared", 3'd0);
  endtask

  initial begin
    #(CLK_PER*5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PER*2 + 1);
    t_reset();
    rst_n = 1;
    t_modes();
    t_nx();
    t_prio();
    t_restrict();
    t_sticky();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule